// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the instruction fetch address of a small microcontroller core whose instructions are 14 bits wide. It holds a 13-bit program counter and advances it once per instruction cycle. The same counter serves absolute jumps, subroutine calls, the two kinds of return and interrupt entry. Calls and interrupt entry save their return address in an eight-entry hardware stack. Each return form takes its destination from that stack.

The decoder in front of the block presents one-cycle strobes together with a 13-bit target address. A change of flow takes two cycles. In the first cycle the new address is loaded. In the second cycle `flush_o` is high, which tells the pipeline to discard the instruction it already fetched. The parameter `MEM_WORDS` selects 2048, 4096 or 8192 words of program memory. The counter keeps all 13 bits, and the emitted fetch address has the bits above the implemented size masked off, so any address folds back into the memory that exists.

Top module: `prog_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, fetch_addr_o is 0000h and flush_o is 0.
- R2: In a cycle with no strobe and no flush, the counter advances by one for the next cycle, and 1FFFh wraps to 0000h.
- R3: jump_i loads target_i into the counter. call_i loads target_i and also pushes the current counter value plus one.
- R4: ret_i and reti_i each pop the stack and load the popped value into the counter. Nested calls return in last-in, first-out order.
- R5: irq_i pushes the current counter value plus one and loads 0004h. Precedence is irq_i, then call_i, then jump_i, then ret_i/reti_i.
- R6: After any taken change of flow, flush_o is 1 for exactly the next cycle. In that cycle the fetch address holds, and every strobe, including irq_i, has no effect.
- R7: fetch_addr_o is the counter with bits 11 and up cleared when MEM_WORDS is 2048, with bits 12 and up cleared when MEM_WORDS is 4096, and unchanged when MEM_WORDS is 8192.
- R8: The stack is circular with eight entries. A ninth push overwrites the oldest entry. Popping past empty wraps the pointer, and no flag is raised.
- R9: Reset clears every stack entry, so a pop right after reset loads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Instruction-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jump_i | input | 1 | Absolute jump strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Return strobe (plain or with literal) |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_i | input | 1 | Interrupt request |
| target_i | input | 13 | Jump or call destination |
| fetch_addr_o | output | 13 | Folded fetch address |
| flush_o | output | 1 | Discard the fetched instruction (branch bubble) |

## Verification
The hardest state to reach from the ports is a stack that has wrapped. That takes more than eight nested calls before any return, followed by returns that run past the bottom. The bench reaches it with ten nested calls on distinct targets and then ten alternating ret/reti pops. The same stimulus feeds three instances sized for 2K, 4K and 8K words. A sweep of 256 jump targets then exercises folding in every upper-address pattern. Strobes and interrupts are also placed in bubble cycles, where they must be ignored.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_HOLD = 3'd1,
    SEL_IRQ  = 3'd2,
    SEL_TGT  = 3'd3,
    SEL_POP  = 3'd4
  } next_sel_e;
endpackage

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      jump_i,
  input  logic      call_i,
  input  logic      ret_i,
  input  logic      reti_i,
  input  logic      irq_i,
  output next_sel_e sel_o,
  output logic      push_o,
  output logic      pop_o,
  output logic      bubble_o
);
  logic bubble_q;
  logic take_irq, take_call, take_jump, take_pop, taken;

  assign take_irq  = !bubble_q && irq_i;
  assign take_call = !bubble_q && !irq_i && call_i;
  assign take_jump = !bubble_q && !irq_i && !call_i && jump_i;
  assign take_pop  = !bubble_q && !irq_i && !call_i && !jump_i && (ret_i || reti_i);
  assign taken     = take_irq || take_call || take_jump || take_pop;

  always_comb begin
    if (bubble_q)                   sel_o = SEL_HOLD;
    else if (take_irq)              sel_o = SEL_IRQ;
    else if (take_call || take_jump) sel_o = SEL_TGT;
    else if (take_pop)              sel_o = SEL_POP;
    else                            sel_o = SEL_INC;
  end

  assign push_o   = take_irq || take_call;
  assign pop_o    = take_pop;
  assign bubble_o = bubble_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bubble_q <= 1'b0;
    else         bubble_q <= taken;
  end

  assert_bubble_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_q |=> !bubble_q);
  assert_bubble_blocks_stack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_q |-> !push_o && !pop_o);
endmodule

// File: rtl/prog_seq_stack.sv
module prog_seq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] top_idx;

  // circular: pointer wraps both ways, no overflow state kept
  assign top_idx = ptr_q - PTR_W'(1);
  assign rdata_o = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= wdata_i;
      ptr_q        <= ptr_q + PTR_W'(1);
    end else if (pop_i) begin
      ptr_q <= top_idx;
    end
  end

  assert_push_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1)));
  assert_pop_retreat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_q == PTR_W'($past(ptr_q) - PTR_W'(1)));
  assert_push_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/prog_seq_fold.sv
module prog_seq_fold #(
  parameter int PC_W      = 13,
  parameter int MEM_WORDS = 8192
) (
  input  logic [PC_W-1:0] addr_i,
  output logic [PC_W-1:0] addr_o
);
  localparam int AW = $clog2(MEM_WORDS);

  generate
    if (AW >= PC_W) begin : g_full
      assign addr_o = addr_i;
    end else begin : g_mask
      assign addr_o = {{(PC_W-AW){1'b0}}, addr_i[AW-1:0]};
    end
  endgenerate
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import prog_seq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int MEM_WORDS   = 8192,
  parameter int STACK_DEPTH = 8,
  parameter int RST_VEC     = 0,
  parameter int IRQ_VEC     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            jump_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            reti_i,
  input  logic            irq_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] fetch_addr_o,
  output logic            flush_o
);
  localparam logic [PC_W:0] ADDR_LIMIT = (PC_W+1)'(MEM_WORDS);

  next_sel_e       sel;
  logic            push, pop, bubble;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, stack_top;

  prog_seq_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .jump_i   (jump_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .reti_i   (reti_i),
    .irq_i    (irq_i),
    .sel_o    (sel),
    .push_o   (push),
    .pop_o    (pop),
    .bubble_o (bubble)
  );

  prog_seq_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) i_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (pc_inc),
    .rdata_o (stack_top)
  );

  prog_seq_fold #(.PC_W(PC_W), .MEM_WORDS(MEM_WORDS)) i_fold (
    .addr_i (pc_q),
    .addr_o (fetch_addr_o)
  );

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    unique case (sel)
      SEL_HOLD: pc_d = pc_q;
      SEL_IRQ:  pc_d = PC_W'(IRQ_VEC);
      SEL_TGT:  pc_d = target_i;
      SEL_POP:  pc_d = stack_top;
      default:  pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_W'(RST_VEC);
    else         pc_q <= pc_d;
  end

  assign flush_o = bubble;

  assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && !irq_i && !call_i && !jump_i && !ret_i && !reti_i)
      |=> pc_q == PC_W'($past(pc_q) + PC_W'(1)));
  assert_target_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && !irq_i && (call_i || jump_i)) |=> pc_q == $past(target_i));
  assert_pop_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && !irq_i && !call_i && !jump_i && (ret_i || reti_i))
      |=> pc_q == $past(stack_top));
  assert_irq_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && irq_i) |=> pc_q == PC_W'(IRQ_VEC));
  assert_flush_after_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && (irq_i || call_i || jump_i || ret_i || reti_i)) |=> flush_o);
  assert_bubble_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> $stable(pc_q));
  assert_fold_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, fetch_addr_o} < ADDR_LIMIT);
endmodule

// File: tb/test_prog_sequencer.sv
`timescale 1ns/1ps
module test_prog_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump = 1'b0, call = 1'b0, ret = 1'b0, reti = 1'b0, irq = 1'b0;
  logic [12:0] tgt = '0;
  logic [12:0] fa8, fa4, fa2;
  logic        fl8, fl4, fl2;

  int checks = 0;
  int errors = 0;
  logic [12:0] m_pc = '0;
  logic        m_bub = 1'b0;
  logic [12:0] m_stk [8];
  int          m_sp = 0;

  always #2.5 clk = ~clk;

  prog_sequencer i_prog_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .jump_i(jump), .call_i(call), .ret_i(ret),
    .reti_i(reti), .irq_i(irq), .target_i(tgt), .fetch_addr_o(fa8), .flush_o(fl8));
  prog_sequencer #(.MEM_WORDS(4096)) i_prog_seq_4k (
    .clk_i(clk), .rst_ni(rst_n), .jump_i(jump), .call_i(call), .ret_i(ret),
    .reti_i(reti), .irq_i(irq), .target_i(tgt), .fetch_addr_o(fa4), .flush_o(fl4));
  prog_sequencer #(.MEM_WORDS(2048)) i_prog_seq_2k (
    .clk_i(clk), .rst_ni(rst_n), .jump_i(jump), .call_i(call), .ret_i(ret),
    .reti_i(reti), .irq_i(irq), .target_i(tgt), .fetch_addr_o(fa2), .flush_o(fl2));

  task automatic chk(input string tag, input string what, input logic [12:0] act,
                     input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %h exp %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input string tag_fold);
    chk(tag, "fetch8k", fa8, m_pc);
    chk(tag_fold, "fetch4k", fa4, m_pc & 13'h0fff);
    chk(tag_fold, "fetch2k", fa2, m_pc & 13'h07ff);
    chk(tag, "flush", {12'd0, fl8}, {12'd0, m_bub});
    chk(tag, "flush4k", {12'd0, fl4}, {12'd0, m_bub});
    chk(tag, "flush2k", {12'd0, fl2}, {12'd0, m_bub});
  endtask

  task automatic push_m(input logic [12:0] v);
    m_stk[m_sp] = v;
    m_sp = (m_sp + 1) % 8;
  endtask

  task automatic step(input string tag, input logic j, input logic c, input logic r,
                      input logic ri, input logic q, input logic [12:0] t);
    @(negedge clk);
    jump = j; call = c; ret = r; reti = ri; irq = q; tgt = t;
    if (m_bub) begin
      m_bub = 1'b0;
    end else if (q) begin
      push_m(m_pc + 13'd1); m_pc = 13'h0004; m_bub = 1'b1;
    end else if (c) begin
      push_m(m_pc + 13'd1); m_pc = t; m_bub = 1'b1;
    end else if (j) begin
      m_pc = t; m_bub = 1'b1;
    end else if (r || ri) begin
      m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; m_bub = 1'b1;
    end else begin
      m_pc = m_pc + 13'd1;
    end
    @(posedge clk);
    #1;
    check_all(tag, "R7");
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, '0);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", "R1");
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    check_all("R1", "R1");

    // R9: pop straight after reset reads a cleared entry
    step("R9", 0, 0, 1, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0);
    idle("R2", 12);

    // R3 jump near the top, R6 strobes in bubble ignored, R2 wrap
    step("R3", 1, 0, 0, 0, 0, 13'h1ffe);
    step("R6", 1, 1, 1, 0, 1, 13'h0abc);
    idle("R2", 4);

    // R8: ten nested calls wrap the stack
    for (int k = 1; k <= 10; k++) begin
      step("R3", 0, 1, 0, 0, 0, 13'(k * 13'h0211 + 3));
      step("R6", 0, 0, 0, 0, 0, '0);
      idle("R2", 1);
    end
    // R4/R8: ten returns, alternating forms, run past empty
    for (int k = 1; k <= 10; k++) begin
      step("R4", 0, 0, (k % 2) == 1, (k % 2) == 0, 0, '0);
      step("R6", 0, 0, 0, 0, 0, '0);
      idle("R2", 1);
    end

    // R5: interrupt beats call and jump, then return to pc+1
    step("R3", 1, 0, 0, 0, 0, 13'h1234);
    step("R6", 0, 0, 0, 0, 0, '0);
    idle("R2", 2);
    step("R5", 1, 1, 0, 0, 1, 13'h0777);
    step("R6", 0, 0, 0, 0, 1, '0);
    idle("R2", 3);
    step("R4", 0, 0, 0, 1, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0);
    // R5: call beats jump and return; jump beats return
    step("R5", 1, 1, 1, 0, 0, 13'h0f00);
    step("R6", 0, 0, 0, 0, 0, '0);
    step("R5", 1, 0, 1, 1, 0, 13'h1801);
    step("R6", 0, 0, 0, 0, 0, '0);
    step("R4", 0, 0, 1, 0, 0, '0);
    step("R6", 0, 0, 0, 0, 0, '0);

    // R7: sweep upper address patterns across all three sizes
    for (int k = 0; k < 256; k++) begin
      step("R7", 1, 0, 0, 0, 0, 13'(k * 32 + (k % 32)));
      step("R6", 0, 0, 0, 0, 0, '0);
      step("R2", 0, 0, 0, 0, 0, '0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule